// File: doc/BRIEF.md
# Root Hub Power and Wakeup Control Register

This block is the hub-wide control and status word of a host controller root hub that serves seven downstream ports. Software reads and writes it over a plain 32-bit register bus. It decides which ports get power, tracks a hub-wide overcurrent condition, and arms remote wakeup on connect events.

Port power is switched by two write-only strobe bits, one that powers ports off and one that powers them on. A mode input selects global switching or per-port switching. In global mode a strobe acts on every port. In per-port mode it acts only on ports whose stored mask bit is clear. The overcurrent input is synchronized and shown as a level bit. A sticky change flag, which software clears by writing 1, goes with it. A stored wakeup enable turns a rising connect-change input during suspend into a one-cycle resume pulse.

Top module: `rh_pwr_ctl`

## Requirements
- R1: After reset, `port_pwr` is 0, `resume_pulse` is 0 and a read returns 0x00000000.
- R2: A read (`bus_rd` high at a clock edge) returns, from the next cycle on, the word as it stood before that edge. Bits 7:1 hold the mask for ports 1 to 7, and each takes the value written on every write. Bits 0, 23:8, 24, 26, 29, 30 and 31 always read 0.
- R3: With `pwr_per_port` = 0, a write with bit 26 = 1 powers on all ports from the next cycle, whatever the mask. A write with bit 24 = 1 powers them all off. `port_pwr` bit i is the power of port i+1.
- R4: With `pwr_per_port` = 1, the bit 24 and bit 26 strobes change only the ports whose mask bit is 0. They use the mask as stored before that write, and masked ports keep their state.
- R5: A write with both bit 24 and bit 26 set turns the affected ports off. A write with both bits 0 leaves `port_pwr` unchanged, and no other input changes it.
- R6: Bit 25 follows `oc_in` two clock edges late (two-stage synchronizer). It reads 0 while `oc_per_port_cfg` = 1.
- R7: Bit 27 is set one edge after the synchronized overcurrent level changes, unless `oc_per_port_cfg` = 1. Writing 1 to bit 27 clears it and writing 0 does not. When a set and a clearing write fall in the same cycle, the bit stays 1.
- R8: Bit 28 (wakeup enable) takes the written value on every write. A write with bit 29 = 1 clears it, and this overrides bit 28 in the same write.
- R9: `resume_pulse` is high for exactly one cycle, the cycle after an edge at which `conn_chg` has risen while `hc_suspended` = 1 and bit 28 = 1. It is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe; data follows next cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwr_per_port | input | 1 | 0 = global switching, 1 = per-port switching |
| oc_per_port_cfg | input | 1 | 1 = overcurrent is reported per port, so the hub bit is hidden |
| oc_in | input | 1 | Asynchronous hub overcurrent level |
| conn_chg | input | 1 | Connect status change indication |
| hc_suspended | input | 1 | Host controller is in the suspend state |
| port_pwr | output | 7 | Power state of ports 1 to 7 |
| resume_pulse | output | 1 | One-cycle resume-detected pulse |

## Verification
Port power and the mask change at the edge that takes the write, and read data appears one cycle after the read strobe edge. The overcurrent level bit lags `oc_in` by two edges and the change flag by three. The resume pulse follows the connect edge by one cycle. The bench drives inputs on the falling edge and steps a behavioural model at each rising edge, so every output is compared in the half cycle where both should have settled. Directed reads then pin literal values at the boundary points: strobe priority, the stored-mask rule and the set-versus-clear collision.

// File: rtl/rh_pwr_pkg.sv
package rh_pwr_pkg;
  localparam int POS_PWR_OFF  = 24;
  localparam int POS_OC_LVL   = 25;
  localparam int POS_PWR_ON   = 26;
  localparam int POS_OC_CHG   = 27;
  localparam int POS_WAKE_EN  = 28;
  localparam int POS_WAKE_CLR = 29;
  localparam int SYNC_STAGES  = 2;
endpackage

// File: rtl/rh_oc_sense.sv
module rh_oc_sense
  import rh_pwr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic oc_in,
  input  logic per_port_cfg,
  input  logic clr_flag,
  output logic oc_level,
  output logic oc_chg
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   chg_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], oc_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign chg_set  = (sync_q[SYNC_STAGES-1] != prev_q) && !per_port_cfg;
  assign oc_level = sync_q[SYNC_STAGES-1] && !per_port_cfg;

  // hardware set has priority over the software clear
  always_ff @(posedge clk) begin
    if (rst)           oc_chg <= 1'b0;
    else if (chg_set)  oc_chg <= 1'b1;
    else if (clr_flag) oc_chg <= 1'b0;
  end
endmodule

// File: rtl/rh_port_switch.sv
module rh_port_switch #(
  parameter int NUM_PORTS = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [NUM_PORTS-1:0] mask_wdata,
  input  logic                 off_stb,
  input  logic                 on_stb,
  input  logic                 per_port,
  output logic [NUM_PORTS-1:0] mask,
  output logic [NUM_PORTS-1:0] port_pwr
);
  always_ff @(posedge clk) begin
    if (rst)     mask <= '0;
    else if (wr) mask <= mask_wdata;
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    logic hit;
    assign hit = !per_port || !mask[g];
    always_ff @(posedge clk) begin
      if (rst)                 port_pwr[g] <= 1'b0;
      else if (off_stb && hit) port_pwr[g] <= 1'b0;
      else if (on_stb && hit)  port_pwr[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/rh_wakeup.sv
module rh_wakeup (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic en_wdata,
  input  logic clr_wdata,
  input  logic conn_chg,
  input  logic suspended,
  output logic wake_en,
  output logic resume_pulse
);
  logic conn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_en      <= 1'b0;
      conn_q       <= 1'b0;
      resume_pulse <= 1'b0;
    end else begin
      if (wr) wake_en <= en_wdata && !clr_wdata;
      conn_q       <= conn_chg;
      resume_pulse <= conn_chg && !conn_q && suspended && wake_en;
    end
  end
endmodule

// File: rtl/rh_pwr_ctl.sv
module rh_pwr_ctl
  import rh_pwr_pkg::*;
#(
  parameter int NUM_PORTS = 7,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 pwr_per_port,
  input  logic                 oc_per_port_cfg,
  input  logic                 oc_in,
  input  logic                 conn_chg,
  input  logic                 hc_suspended,
  output logic [NUM_PORTS-1:0] port_pwr,
  output logic                 resume_pulse
);
  localparam int MASK_LO = 1;
  localparam int MASK_HI = NUM_PORTS;

  logic [NUM_PORTS-1:0] mask;
  logic                 oc_level;
  logic                 oc_chg;
  logic                 wake_en;
  logic [DATA_W-1:0]    rd_word;
  logic                 unused_wbits;

  assign unused_wbits = ^{bus_wdata[DATA_W-1:POS_WAKE_CLR+1], bus_wdata[POS_OC_LVL],
                          bus_wdata[POS_PWR_OFF-1:MASK_HI+1], bus_wdata[0]};

  rh_port_switch #(.NUM_PORTS(NUM_PORTS)) u_switch (
    .clk        (clk),
    .rst        (rst),
    .wr         (bus_wr),
    .mask_wdata (bus_wdata[MASK_HI:MASK_LO]),
    .off_stb    (bus_wr && bus_wdata[POS_PWR_OFF]),
    .on_stb     (bus_wr && bus_wdata[POS_PWR_ON]),
    .per_port   (pwr_per_port),
    .mask       (mask),
    .port_pwr   (port_pwr)
  );

  rh_oc_sense u_oc (
    .clk          (clk),
    .rst          (rst),
    .oc_in        (oc_in),
    .per_port_cfg (oc_per_port_cfg),
    .clr_flag     (bus_wr && bus_wdata[POS_OC_CHG]),
    .oc_level     (oc_level),
    .oc_chg       (oc_chg)
  );

  rh_wakeup u_wake (
    .clk          (clk),
    .rst          (rst),
    .wr           (bus_wr),
    .en_wdata     (bus_wdata[POS_WAKE_EN]),
    .clr_wdata    (bus_wdata[POS_WAKE_CLR]),
    .conn_chg     (conn_chg),
    .suspended    (hc_suspended),
    .wake_en      (wake_en),
    .resume_pulse (resume_pulse)
  );

  always_comb begin
    rd_word                   = '0;
    rd_word[MASK_HI:MASK_LO]  = mask;
    rd_word[POS_OC_LVL]       = oc_level;
    rd_word[POS_OC_CHG]       = oc_chg;
    rd_word[POS_WAKE_EN]      = wake_en;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/rh_pwr_ctl_chk.sv
module rh_pwr_ctl_chk
  import rh_pwr_pkg::*;
#(
  parameter int NUM_PORTS = 7,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic                 pwr_per_port,
  input logic                 oc_per_port_cfg,
  input logic                 oc_in,
  input logic                 conn_chg,
  input logic                 hc_suspended,
  input logic [NUM_PORTS-1:0] port_pwr,
  input logic                 resume_pulse
);
  logic unused_chk;
  assign unused_chk = oc_in;

  // R5
  pwr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_wr) |-> $stable(port_pwr));

  // R3
  global_on_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && bus_wdata[POS_PWR_ON] && !bus_wdata[POS_PWR_OFF] && !pwr_per_port)
    |-> (&port_pwr));

  // R5
  off_wins_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && bus_wdata[POS_PWR_OFF] && !pwr_per_port) |-> (port_pwr == '0));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[DATA_W-1:POS_WAKE_CLR] == '0) && !bus_rdata[POS_PWR_ON] &&
    !bus_rdata[POS_PWR_OFF] && (bus_rdata[POS_PWR_OFF-1:NUM_PORTS+1] == '0) && !bus_rdata[0]);

  // R6
  oc_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && oc_per_port_cfg) |-> !bus_rdata[POS_OC_LVL]);

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    resume_pulse |=> !resume_pulse);

  // R9
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    resume_pulse |-> $past(conn_chg && hc_suspended));
endmodule

bind rh_pwr_ctl rh_pwr_ctl_chk #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_rh_pwr_ctl.sv
`timescale 1ns/1ps
module tb_rh_pwr_ctl;
  localparam int NP = 7;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic pwr_per_port = 0, oc_per_port_cfg = 0, oc_in = 0, conn_chg = 0, hc_suspended = 0;
  logic [NP-1:0] port_pwr;
  logic resume_pulse;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rh_pwr_ctl dut (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_per_port(pwr_per_port),
    .oc_per_port_cfg(oc_per_port_cfg), .oc_in(oc_in), .conn_chg(conn_chg),
    .hc_suspended(hc_suspended), .port_pwr(port_pwr), .resume_pulse(resume_pulse));

  // behavioural reference model, stepped on each rising edge
  bit m_mask[1:NP];
  bit m_pwr[1:NP];
  bit m_oc_q[$];
  bit m_chg, m_wake, m_conn_prev, m_resume;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_word();
    logic [31:0] w = 0;
    for (int p = 1; p <= NP; p++) w[p] = m_mask[p];
    w[25] = m_oc_q[1] && !oc_per_port_cfg;
    w[27] = m_chg;
    w[28] = m_wake;
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 1; p <= NP; p++) begin m_mask[p] = 0; m_pwr[p] = 0; end
      m_oc_q = '{0, 0, 0};
      m_chg = 0; m_wake = 0; m_conn_prev = 0; m_resume = 0; m_rdata = 0;
    end else begin
      bit set_chg;
      if (bus_rd) m_rdata = m_word();
      m_resume = conn_chg && !m_conn_prev && hc_suspended && m_wake;
      m_conn_prev = conn_chg;
      set_chg = (m_oc_q[1] != m_oc_q[2]) && !oc_per_port_cfg;
      if (set_chg) m_chg = 1;
      else if (bus_wr && bus_wdata[27]) m_chg = 0;
      m_oc_q.pop_back();
      m_oc_q.push_front(oc_in);
      if (bus_wr) begin
        for (int p = 1; p <= NP; p++) begin
          if (!pwr_per_port || !m_mask[p]) begin
            if (bus_wdata[24]) m_pwr[p] = 0;
            else if (bus_wdata[26]) m_pwr[p] = 1;
          end
        end
        for (int p = 1; p <= NP; p++) m_mask[p] = bus_wdata[p];
        m_wake = bus_wdata[28] && !bus_wdata[29];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [NP-1:0] e;
      for (int p = 1; p <= NP; p++) e[p-1] = m_pwr[p];
      check("R3 model port_pwr", {25'd0, port_pwr}, {25'd0, e});
      check("R2 model rdata", bus_rdata, m_rdata);
      check("R9 model resume", {31'd0, resume_pulse}, {31'd0, m_resume});
    end
  end

  task automatic wr(input logic [31:0] d);
    bus_wr = 1; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(output logic [31:0] d);
    bus_rd = 1;
    @(posedge clk); @(negedge clk);
    bus_rd = 0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    idle(3);
    @(negedge clk); rst = 0;
    idle(1);
    check("R1 port_pwr", {25'd0, port_pwr}, 0);
    check("R1 resume", {31'd0, resume_pulse}, 0);
    rd(r); check("R1 read", r, 32'h0);
    // register layout
    wr(32'hC00000AB); rd(r); check("R2 mask readback", r, 32'h000000AA);
    check("R5 no strobe", {25'd0, port_pwr}, 0);
    // global mode
    wr(32'h040000AA); check("R3 global on", {25'd0, port_pwr}, 32'h7F);
    wr(32'h010000AA); check("R3 global off", {25'd0, port_pwr}, 0);
    wr(32'h040000AA);
    wr(32'h050000AA); check("R5 both global", {25'd0, port_pwr}, 0);
    // per-port mode
    pwr_per_port = 1;
    wr(32'h040000AA); check("R4 unmasked on", {25'd0, port_pwr}, 32'h2A);
    wr(32'h01000000); check("R4 old mask off", {25'd0, port_pwr}, 0);
    wr(32'h04000000); check("R4 mask clear on", {25'd0, port_pwr}, 32'h7F);
    wr(32'h010000FE); check("R4 old mask all", {25'd0, port_pwr}, 0);
    wr(32'h040000FE); check("R4 all masked", {25'd0, port_pwr}, 0);
    wr(32'h05000000); check("R4 masked both", {25'd0, port_pwr}, 0);
    wr(32'h04000000);
    wr(32'h05000000); check("R5 both per-port", {25'd0, port_pwr}, 0);
    wr(32'h04000000);
    wr(32'h00000000); check("R5 zero write", {25'd0, port_pwr}, 32'h7F);
    // overcurrent
    oc_in = 1; idle(4);
    rd(r); check("R6 level and R7 flag", r, 32'h0A000000);
    wr(32'h00000000); rd(r); check("R7 write 0 keeps", r, 32'h0A000000);
    wr(32'h08000000); rd(r); check("R7 write 1 clears", r, 32'h02000000);
    oc_in = 0; idle(2);
    wr(32'h08000000); rd(r); check("R7 set beats clear", r, 32'h08000000);
    wr(32'h08000000); rd(r); check("R7 cleared", r, 32'h0);
    oc_per_port_cfg = 1; oc_in = 1; idle(4);
    rd(r); check("R6 hidden and R7 no set", r, 32'h0);
    oc_per_port_cfg = 0;
    rd(r); check("R6 visible again", r, 32'h02000000);
    oc_in = 0; idle(4);
    wr(32'h08000000); rd(r); check("R7 final clear", r, 32'h0);
    // wakeup
    wr(32'h10000000); rd(r); check("R8 enable", r, 32'h10000000);
    conn_chg = 1; idle(1); check("R9 not suspended", {31'd0, resume_pulse}, 0);
    conn_chg = 0; idle(1);
    hc_suspended = 1; conn_chg = 1; idle(1);
    check("R9 pulse", {31'd0, resume_pulse}, 1);
    idle(1); check("R9 one cycle", {31'd0, resume_pulse}, 0);
    conn_chg = 0; idle(1);
    wr(32'h30000000); rd(r); check("R8 clear wins", r, 32'h0);
    conn_chg = 1; idle(1); check("R9 disabled", {31'd0, resume_pulse}, 0);
    conn_chg = 0;
    wr(32'h10000000);
    wr(32'h20000000); rd(r); check("R8 clear strobe", r, 32'h0);
    idle(3);
    finish_run();
  end
endmodule